// File: doc/BRIEF.md
# Sticky Serial-IRQ Status Register

This block collects level interrupt requests from the peripheral devices behind a bus host controller. It holds them as sticky status bits that software reads and clears through a small register port. Each request source owns one bit of a 32-bit status word. Source 0 sits in the top bit, and each later source takes the next lower bit. A companion mask word, with the same bit layout, selects which latched bits may reach the CPU. The block drives a single registered interrupt line, which is the OR of the status bits that the mask enables.

The block samples each request into an internal level record before it acts on it. That record follows the request both up and down. The latched status bit is separate from it and is released only by software. A write of ones to the status word clears the selected bits, but only for sources whose recorded level is low. A clear therefore cannot drop a request that is still being held, and no interrupt is lost.

Top module: `sirq_status_reg`

## Requirements
- R1: When a request input is high at a clock edge, the level record captures it. The status bit of that source reads 1 after the following edge, which is the second edge after the input rose.
- R2: A write with `sel_i`=0 clears each status bit whose write-data bit is 1 and whose source is recorded low. Status bits whose write-data bit is 0 keep their value.
- R3: A clear aimed at a source whose recorded level is high is ignored, and the status bit stays 1.
- R4: The level record follows deassertion as well as assertion. Two edges after a request falls, a clear of its bit takes effect.
- R5: A falling request does not change its status bit. Only a software write can return the bit to 0.
- R6: Source n is held at register bit 31-n in both words. With 16 sources, bits 31..16 are assigned. `sel_i`=0 addresses the status word and `sel_i`=1 addresses the mask word.
- R7: `irq_o` is registered. It equals the OR of (status AND mask) as it stood before the previous edge, so it trails any status or mask change by one cycle.
- R8: The mask word can be written and read back. A write to the status word leaves the mask word unchanged.
- R9: While reset is held, status, mask, level record and `irq_o` are all 0. Unassigned bit positions read as 0, and writes to those positions are ignored in both words.
- R10: If a status bit is set and cleared on the same edge, the set wins and the bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Level request from each source, active high |
| wr_en_i | input | 1 | Write strobe for the selected word |
| sel_i | input | 1 | Word select: 0 status, 1 mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read of the selected word |
| irq_o | output | 1 | Registered interrupt to the CPU interrupt controller |

## Verification
The bench targets the hazard this block exists to remove. It writes a clear while a request is still held and expects the bit to survive. A design that applies the write-one-to-clear without gating would lose that interrupt. It also lowers a request and checks that the bit persists until software clears it, which catches a design that only mirrors the input levels. A write that lands on the same edge as a new set must leave the bit at 1. The bench counts edges from request to status to `irq_o`, which exposes a missing or extra pipeline stage. It also checks the bit ordering and the unassigned positions, which catch a reversed source mapping or stray storage in the low bits.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;
  localparam int REG_W = 32;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sirq_level_rec.sv
`timescale 1ns/1ps
// Registered record of the live request levels
module sirq_level_rec #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] level_o
);
  logic [NUM_SRC-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= req_i;
  end

  assign level_o = level_q;

  AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> level_o == $past(req_i)); // R4
endmodule

// File: rtl/sirq_status_bank.sv
`timescale 1ns/1ps
// Sticky per-source status bits, clear gated by recorded level
module sirq_status_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] st_q;
  logic [NUM_SRC-1:0] clr_ok;

  assign clr_ok = clr_i & ~level_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          st_q[g] <= 1'b0;
      else if (level_i[g])  st_q[g] <= 1'b1;  // set has priority
      else if (clr_ok[g])   st_q[g] <= 1'b0;
    end

    AST_SET_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_i[g] |=> status_o[g]); // R1
    AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && level_i[g]) |=> status_o[g]); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !level_i[g]) |=> !status_o[g]); // R2
    AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[g] && !clr_i[g]) |=> status_o[g]); // R5
  end

  assign status_o = st_q;
endmodule

// File: rtl/sirq_mask_reg.sv
`timescale 1ns/1ps
// Per-source interrupt enable
module sirq_mask_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_o)); // R8
endmodule

// File: rtl/sirq_irq_comb.sv
`timescale 1ns/1ps
// Registered OR of enabled status bits
module sirq_irq_comb #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> irq_o == $past(|(status_i & mask_i))); // R7
endmodule

// File: rtl/sirq_status_reg.sv
`timescale 1ns/1ps
module sirq_status_reg #(
  parameter int NUM_SRC = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SRC-1:0]         req_i,
  input  logic                       wr_en_i,
  input  logic                       sel_i,
  input  logic [sirq_pkg::REG_W-1:0] wdata_i,
  output logic [sirq_pkg::REG_W-1:0] rdata_o,
  output logic                       irq_o
);
  import sirq_pkg::*;

  localparam int TOP_BIT = REG_W - 1;

  logic [NUM_SRC-1:0] level;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] src_wdata;
  logic [NUM_SRC-1:0] clr_vec;
  logic               wr_status;
  logic               wr_mask;
  logic [REG_W-1:0]   status_word;
  logic [REG_W-1:0]   mask_word;

  assign wr_status = wr_en_i && (reg_sel_e'(sel_i) == SEL_STATUS);
  assign wr_mask   = wr_en_i && (reg_sel_e'(sel_i) == SEL_MASK);

  // Source n <-> register bit TOP_BIT-n
  always_comb begin
    status_word = '0;
    mask_word   = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      src_wdata[n]           = wdata_i[TOP_BIT-n];
      status_word[TOP_BIT-n] = status[n];
      mask_word[TOP_BIT-n]   = mask[n];
    end
  end

  assign clr_vec = wr_status ? src_wdata : '0;
  assign rdata_o = (reg_sel_e'(sel_i) == SEL_MASK) ? mask_word : status_word;

  sirq_level_rec #(.NUM_SRC(NUM_SRC)) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .level_o (level)
  );

  sirq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  sirq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_mask),
    .wdata_i (src_wdata),
    .mask_o  (mask)
  );

  sirq_irq_comb #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );

  AST_MASK_ON_STATUS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_status |=> $stable(mask)); // R8
endmodule

// File: tb/sirq_status_reg_test.sv
`timescale 1ns/1ps
module sirq_status_reg_test;
  localparam int NS = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] req_i = '0;
  logic          wr_en_i = 1'b0;
  logic          sel_i = 1'b0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  sirq_status_reg #(.NUM_SRC(NS)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_en_i(wr_en_i),
    .sel_i(sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] bit_of(int src);
    return 32'h1 << (31 - src);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    sel_i = sel; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    sel_i = sel;
    #1 d = rdata_o;
  endtask

  task automatic pulse(logic [NS-1:0] v);
    req_i = v; tick(1); req_i = '0; tick(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, d); chk("R9 status in reset", d, 32'h0);
    rd(1'b1, d); chk("R9 mask in reset", d, 32'h0);
    chk("R9 irq in reset", {31'h0, irq_o}, 32'h0);
    rst_ni = 1'b1; tick(1);
  endtask

  task automatic t_set_sticky();
    logic [31:0] d;
    req_i[3] = 1'b1; tick(1);
    rd(1'b0, d); chk("R1 not yet set after one edge", d, 32'h0);
    tick(1);
    rd(1'b0, d); chk("R1 set after two edges", d, bit_of(3));
    req_i[3] = 1'b0; tick(3);
    rd(1'b0, d); chk("R5 sticky after deassert", d, bit_of(3));
    wr(1'b0, bit_of(3));
    rd(1'b0, d); chk("R4 clear after deassert recorded", d, 32'h0);
  endtask

  task automatic t_clear_blocked();
    logic [31:0] d;
    req_i[0] = 1'b1; tick(2);
    wr(1'b0, 32'hFFFF_FFFF);
    tick(1);
    rd(1'b0, d); chk("R3 clear ignored while held", d, 32'h8000_0000);
    req_i[0] = 1'b0; tick(1);
    rd(1'b0, d); chk("R5 held after drop", d, 32'h8000_0000);
    wr(1'b0, 32'h8000_0000);
    rd(1'b0, d); chk("R4 clear after drop", d, 32'h0);
  endtask

  task automatic t_w1c_partial();
    logic [31:0] d;
    logic [31:0] all3;
    all3 = bit_of(1) | bit_of(5) | bit_of(9);
    pulse(16'h0222);
    rd(1'b0, d); chk("R1 three sources", d, all3);
    wr(1'b0, bit_of(5));
    rd(1'b0, d); chk("R2 partial clear", d, bit_of(1) | bit_of(9));
    wr(1'b0, 32'h0);
    rd(1'b0, d); chk("R2 zero write no effect", d, bit_of(1) | bit_of(9));
    wr(1'b0, all3);
    rd(1'b0, d); chk("R2 clear rest", d, 32'h0);
  endtask

  task automatic t_mapping();
    logic [31:0] d;
    pulse(16'h8000);
    rd(1'b0, d); chk("R6 source 15 at bit 16", d, 32'h0001_0000);
    wr(1'b0, 32'h0001_0000);
    pulse(16'h0001);
    rd(1'b0, d); chk("R6 source 0 at bit 31", d, 32'h8000_0000);
    wr(1'b0, 32'h8000_0000);
  endtask

  task automatic t_mask_irq();
    logic [31:0] d;
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R9 mask unassigned ignored", d, 32'hFFFF_0000);
    wr(1'b1, 32'h0);
    pulse(16'h0004);
    chk("R7 masked no irq", {31'h0, irq_o}, 32'h0);
    wr(1'b1, bit_of(2));
    rd(1'b1, d); chk("R8 mask readback", d, bit_of(2));
    chk("R7 irq one cycle late", {31'h0, irq_o}, 32'h0);
    tick(1);
    chk("R7 irq after mask", {31'h0, irq_o}, 32'h1);
    wr(1'b0, bit_of(2));
    rd(1'b1, d); chk("R8 mask kept on status write", d, bit_of(2));
    chk("R7 irq lags clear", {31'h0, irq_o}, 32'h1);
    tick(1);
    chk("R7 irq drops", {31'h0, irq_o}, 32'h0);
    req_i[2] = 1'b1; tick(2);
    chk("R7 irq not before status", {31'h0, irq_o}, 32'h0);
    tick(1);
    chk("R7 irq from request", {31'h0, irq_o}, 32'h1);
    req_i[2] = 1'b0; tick(2);
    wr(1'b0, bit_of(2)); wr(1'b1, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    req_i[7] = 1'b1; tick(1);
    wr(1'b0, bit_of(7));
    rd(1'b0, d); chk("R10 set wins", d, bit_of(7));
    req_i[7] = 1'b0; tick(1);
    wr(1'b0, bit_of(7));
    rd(1'b0, d); chk("R10 cleanup", d, 32'h0);
  endtask

  task automatic t_unassigned();
    logic [31:0] d;
    wr(1'b0, 32'h0000_FFFF);
    pulse(16'h8000);
    wr(1'b0, 32'h0000_FFFF);
    rd(1'b0, d); chk("R9 low bits write ignored", d, 32'h0001_0000);
    wr(1'b0, 32'h0001_0000);
    rd(1'b0, d); chk("R9 status clean", d, 32'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(3);
    t_reset();
    t_set_sticky();
    t_clear_blocked();
    t_w1c_partial();
    t_mapping();
    t_mask_irq();
    t_collision();
    t_unassigned();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule